// File: doc/BRIEF.md
# Endian-Aware Element-Width Register File

This block is a file of 128 general registers, each 64 bits wide. A register can be accessed in two ways. A scalar access reads or writes the whole register. An element access treats a run of consecutive registers as one packed vector of 8-, 16-, 32- or 64-bit elements. For an element access the caller supplies four inputs: a base register, an element index, a width code and an endian flag. The block works out which register holds the element and which byte lane within that register the element starts at.

Elements are packed from the base register upward. When an element runs past the eighth byte, it continues in the next register. In big-endian mode the element's starting lane is mirrored inside its register, so element 0 sits at the most significant end. An element write changes only the bytes of that element. An element read returns the element zero-extended to 64 bits. The block has one combinational read port and one write port that commits on the clock edge. Both ports report when an element access would land beyond the last register, and such a write is dropped.

Top module: `elem_regfile`

## Requirements
- R1: An active-low reset clears every register to zero, and a scalar read of any register then returns 0.
- R2: A scalar write stores all 64 bits of the data into the base register, whatever the endian flag. A scalar read returns all 64 bits of the base register.
- R3: The width code selects the element size: 2'b00 is 8 bytes, 2'b01 is 4 bytes, 2'b10 is 2 bytes and 2'b11 is 1 byte. The byte offset is the index times the size. The target register is the base plus the byte offset divided by 8.
- R4: In little-endian mode (endian flag 0), the starting lane is the byte offset modulo 8. Lane k holds register bits 8k+7 down to 8k.
- R5: In big-endian mode (endian flag 1), the starting lane is the byte offset modulo 8, XORed with 8 minus the element size.
- R6: An element write changes only the size-many bytes starting at its lane. The other bytes of the register keep their contents. Only the element's low bits are taken from the write data.
- R7: An element read returns the element's bytes, taken lowest lane first, in the low bits of the output. All higher bits are zero.
- R8: If an element access computes a register number above 127, the port's out-of-range output is 1. An out-of-range write changes no register, and an out-of-range read returns 0.
- R9: A read in the same cycle as a write to the same bytes returns the old contents. The new contents are visible from the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request, committed on the rising edge |
| wrScalar | input | 1 | 1: whole-register write; 0: element write |
| wrBase | input | 7 | Write base register |
| wrIndex | input | 10 | Write element index |
| wrWidth | input | 2 | Write element width code |
| wrBigEnd | input | 1 | Write endian flag (1 = big-endian) |
| wrData | input | 64 | Write data, element in the low bits |
| wrOutOfRange | output | 1 | Write target lies past the last register |
| rdScalar | input | 1 | 1: whole-register read; 0: element read |
| rdBase | input | 7 | Read base register |
| rdIndex | input | 10 | Read element index |
| rdWidth | input | 2 | Read element width code |
| rdBigEnd | input | 1 | Read endian flag (1 = big-endian) |
| rdData | output | 64 | Read data, zero-extended element |
| rdOutOfRange | output | 1 | Read target lies past the last register |

## Verification
Some rules are checked by assertions on every cycle. An out-of-range write never raises the internal write strobe, and an out-of-range read returns zero. A scalar write always enables all eight byte lanes of its base register. An element write enables exactly as many lanes as its size. Narrow reads have all upper bits clear. A scalar write is visible to a scalar read of the same register on the next cycle. The exact lane placement can only be shown by the bench's scenarios: the mirroring in big-endian mode, carry into the next register, preservation of neighbouring bytes, and the two 16-bit examples on register 5. The bench shows each of these by reading back whole registers after each write.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  localparam int NUM_REGS  = 128;
  localparam int REG_BYTES = 8;
  localparam int DATA_W    = REG_BYTES * 8;
  localparam int REGNUM_W  = $clog2(NUM_REGS);
  localparam int LANE_W    = $clog2(REG_BYTES);

  typedef struct packed {
    logic                 wrStrobe;
    logic [REGNUM_W-1:0]  wrReg;
    logic [REG_BYTES-1:0] byteMask;
    logic [LANE_W-1:0]    wrLane;
  } wrCtl_t;

  typedef struct packed {
    logic                 rdValid;
    logic [REGNUM_W-1:0]  rdReg;
    logic [REG_BYTES-1:0] sizeMask;
    logic [LANE_W-1:0]    rdLane;
  } rdCtl_t;
endpackage

// File: rtl/ewrf_addr_calc.sv
module ewrf_addr_calc
  import ewrf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                 isScalar,
  input  logic [REGNUM_W-1:0]  baseReg,
  input  logic [IDX_W-1:0]     elemIdx,
  input  logic [1:0]           elemWidth,
  input  logic                 bigEnd,
  output logic [REGNUM_W-1:0]  regNum,
  output logic [LANE_W-1:0]    lane,
  output logic [REG_BYTES-1:0] sizeMask,
  output logic                 outOfRange
);
  localparam int OFF_W = IDX_W + LANE_W;
  localparam int SUM_W = IDX_W + 1;

  logic [1:0]        sizeLog2;
  logic [OFF_W-1:0]  byteOff;
  logic [SUM_W-1:0]  regSum;
  logic [LANE_W-1:0] mirror;

  always_comb begin
    // width code 00 -> 8 bytes ... 11 -> 1 byte
    sizeLog2 = isScalar ? 2'd3 : (2'd3 - elemWidth);
    byteOff  = isScalar ? '0 : (OFF_W'(elemIdx) << sizeLog2);
    regSum   = SUM_W'(baseReg) + SUM_W'(byteOff >> LANE_W);
    // 8 - size, reduced to lane width
    mirror   = ~LANE_W'((1 << sizeLog2) - 1);
    lane     = byteOff[LANE_W-1:0] ^ ((bigEnd && !isScalar) ? mirror : '0);
    sizeMask = REG_BYTES'((1 << (1 << sizeLog2)) - 1);
    regNum   = regSum[REGNUM_W-1:0];
    outOfRange = (regSum >= SUM_W'(NUM_REGS));
  end
endmodule

// File: rtl/ewrf_ctrl.sv
module ewrf_ctrl
  import ewrf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                wrEn,
  input  logic                wrScalar,
  input  logic [REGNUM_W-1:0] wrBase,
  input  logic [IDX_W-1:0]    wrIndex,
  input  logic [1:0]          wrWidth,
  input  logic                wrBigEnd,
  input  logic                rdScalar,
  input  logic [REGNUM_W-1:0] rdBase,
  input  logic [IDX_W-1:0]    rdIndex,
  input  logic [1:0]          rdWidth,
  input  logic                rdBigEnd,
  output wrCtl_t              wrCtl,
  output rdCtl_t              rdCtl,
  output logic                wrOutOfRange,
  output logic                rdOutOfRange
);
  logic [REGNUM_W-1:0]  wrRegNum;
  logic [LANE_W-1:0]    wrLane;
  logic [REG_BYTES-1:0] wrSizeMask;

  logic [REGNUM_W-1:0]  rdRegNum;
  logic [LANE_W-1:0]    rdLane;
  logic [REG_BYTES-1:0] rdSizeMask;

  ewrf_addr_calc #(.IDX_W(IDX_W)) u_wrAddr (
    .isScalar  (wrScalar),
    .baseReg   (wrBase),
    .elemIdx   (wrIndex),
    .elemWidth (wrWidth),
    .bigEnd    (wrBigEnd),
    .regNum    (wrRegNum),
    .lane      (wrLane),
    .sizeMask  (wrSizeMask),
    .outOfRange(wrOutOfRange)
  );

  ewrf_addr_calc #(.IDX_W(IDX_W)) u_rdAddr (
    .isScalar  (rdScalar),
    .baseReg   (rdBase),
    .elemIdx   (rdIndex),
    .elemWidth (rdWidth),
    .bigEnd    (rdBigEnd),
    .regNum    (rdRegNum),
    .lane      (rdLane),
    .sizeMask  (rdSizeMask),
    .outOfRange(rdOutOfRange)
  );

  always_comb begin
    wrCtl.wrStrobe = wrEn && !wrOutOfRange;
    wrCtl.wrReg    = wrRegNum;
    wrCtl.byteMask = wrSizeMask << wrLane;
    wrCtl.wrLane   = wrLane;

    rdCtl.rdValid  = !rdOutOfRange;
    rdCtl.rdReg    = rdRegNum;
    rdCtl.sizeMask = rdSizeMask;
    rdCtl.rdLane   = rdLane;
  end
endmodule

// File: rtl/ewrf_datapath.sv
module ewrf_datapath
  import ewrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrCtl_t            wrCtl,
  input  rdCtl_t            rdCtl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regMem [NUM_REGS];
  logic [DATA_W-1:0] wrShifted;
  logic [DATA_W-1:0] rdRaw;
  logic [DATA_W-1:0] rdBitMask;

  assign wrShifted = wrData << {wrCtl.wrLane, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regMem[r] <= '0;
    end else if (wrCtl.wrStrobe) begin
      for (int b = 0; b < REG_BYTES; b++) begin
        if (wrCtl.byteMask[b]) regMem[wrCtl.wrReg][b*8 +: 8] <= wrShifted[b*8 +: 8];
      end
    end
  end

  // expand the byte-size mask into a bit mask, one lane at a time
  for (genvar g = 0; g < REG_BYTES; g++) begin : gRdMask
    assign rdBitMask[g*8 +: 8] = {8{rdCtl.sizeMask[g]}};
  end

  assign rdRaw  = regMem[rdCtl.rdReg] >> {rdCtl.rdLane, 3'b000};
  assign rdData = rdCtl.rdValid ? (rdRaw & rdBitMask) : '0;
endmodule

// File: rtl/elem_regfile.sv
module elem_regfile
  import ewrf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrScalar,
  input  logic [REGNUM_W-1:0] wrBase,
  input  logic [IDX_W-1:0]    wrIndex,
  input  logic [1:0]          wrWidth,
  input  logic                wrBigEnd,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wrOutOfRange,
  input  logic                rdScalar,
  input  logic [REGNUM_W-1:0] rdBase,
  input  logic [IDX_W-1:0]    rdIndex,
  input  logic [1:0]          rdWidth,
  input  logic                rdBigEnd,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdOutOfRange
);
  wrCtl_t wrCtl;
  rdCtl_t rdCtl;

  ewrf_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .wrEn        (wrEn),
    .wrScalar    (wrScalar),
    .wrBase      (wrBase),
    .wrIndex     (wrIndex),
    .wrWidth     (wrWidth),
    .wrBigEnd    (wrBigEnd),
    .rdScalar    (rdScalar),
    .rdBase      (rdBase),
    .rdIndex     (rdIndex),
    .rdWidth     (rdWidth),
    .rdBigEnd    (rdBigEnd),
    .wrCtl       (wrCtl),
    .rdCtl       (rdCtl),
    .wrOutOfRange(wrOutOfRange),
    .rdOutOfRange(rdOutOfRange)
  );

  ewrf_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wrCtl (wrCtl),
    .rdCtl (rdCtl),
    .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: rtl/elem_regfile_chk.sv
module elem_regfile_chk
  import ewrf_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                wrScalar,
  input logic [REGNUM_W-1:0] wrBase,
  input logic [1:0]          wrWidth,
  input logic [DATA_W-1:0]   wrData,
  input logic                wrOutOfRange,
  input logic                rdScalar,
  input logic [REGNUM_W-1:0] rdBase,
  input logic [1:0]          rdWidth,
  input logic [DATA_W-1:0]   rdData,
  input logic                rdOutOfRange,
  input wrCtl_t              wrCtl
);
  AST_OOR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrOutOfRange |-> !wrCtl.wrStrobe); // R8

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdOutOfRange |-> (rdData == '0)); // R8

  AST_SCALAR_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrScalar) |-> (wrCtl.wrStrobe && (wrCtl.byteMask == '1) && (wrCtl.wrReg == wrBase))); // R2

  AST_ELEM_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl.wrStrobe && !wrScalar) |-> ($countones(wrCtl.byteMask) == (REG_BYTES >> wrWidth))); // R6

  AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (!rdScalar && (rdWidth != 2'b00)) |-> ((rdData >> (DATA_W >> rdWidth)) == '0)); // R7

  AST_WRITE_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && wrScalar) && rdScalar && (rdBase == $past(wrBase))) |-> (rdData == $past(wrData))); // R9
endmodule

bind elem_regfile elem_regfile_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrScalar    (wrScalar),
  .wrBase      (wrBase),
  .wrWidth     (wrWidth),
  .wrData      (wrData),
  .wrOutOfRange(wrOutOfRange),
  .rdScalar    (rdScalar),
  .rdBase      (rdBase),
  .rdWidth     (rdWidth),
  .rdData      (rdData),
  .rdOutOfRange(rdOutOfRange),
  .wrCtl       (wrCtl)
);

// File: tb/elem_regfile_bench.sv
`timescale 1ns/1ps
module elem_regfile_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrScalar = 1'b0, wrBigEnd = 1'b0;
  logic [6:0]  wrBase = '0;
  logic [9:0]  wrIndex = '0;
  logic [1:0]  wrWidth = '0;
  logic [63:0] wrData = '0;
  logic        wrOutOfRange;
  logic        rdScalar = 1'b1, rdBigEnd = 1'b0;
  logic [6:0]  rdBase = '0;
  logic [9:0]  rdIndex = '0;
  logic [1:0]  rdWidth = '0;
  logic [63:0] rdData;
  logic        rdOutOfRange;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  elem_regfile u_elem_regfile (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrScalar(wrScalar), .wrBase(wrBase), .wrIndex(wrIndex),
    .wrWidth(wrWidth), .wrBigEnd(wrBigEnd), .wrData(wrData), .wrOutOfRange(wrOutOfRange),
    .rdScalar(rdScalar), .rdBase(rdBase), .rdIndex(rdIndex), .rdWidth(rdWidth),
    .rdBigEnd(rdBigEnd), .rdData(rdData), .rdOutOfRange(rdOutOfRange)
  );

  typedef struct packed {
    logic        sc;
    logic [6:0]  base;
    logic [9:0]  idx;
    logic [1:0]  w;
    logic        be;
    logic [63:0] data;
    logic [6:0]  chkReg;
    logic [63:0] expReg;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 7'd5,  10'd0, 2'd0, 1'b1, 64'h1234,                7'd5,  64'h1234},
    '{1'b0, 7'd5,  10'd0, 2'd2, 1'b1, 64'h1122,                7'd5,  64'h1122_0000_0000_1234},
    '{1'b1, 7'd6,  10'd0, 2'd0, 1'b0, 64'h1234,                7'd6,  64'h1234},
    '{1'b0, 7'd6,  10'd0, 2'd2, 1'b0, 64'h2356,                7'd6,  64'h2356},
    '{1'b0, 7'd10, 10'd9, 2'd3, 1'b0, 64'hAB,                  7'd11, 64'hAB00},
    '{1'b0, 7'd12, 10'd9, 2'd3, 1'b1, 64'hCD,                  7'd13, 64'h00CD_0000_0000_0000},
    '{1'b0, 7'd20, 10'd3, 2'd1, 1'b1, 64'hDEADBEEF,            7'd21, 64'hDEADBEEF},
    '{1'b0, 7'd30, 10'd3, 2'd1, 1'b0, 64'hDEADBEEF,            7'd31, 64'hDEADBEEF_0000_0000},
    '{1'b0, 7'd40, 10'd2, 2'd0, 1'b1, 64'h0123_4567_89AB_CDEF, 7'd42, 64'h0123_4567_89AB_CDEF},
    '{1'b1, 7'd50, 10'd0, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 7'd50, 64'hFFFF_FFFF_FFFF_FFFF},
    '{1'b0, 7'd50, 10'd2, 2'd3, 1'b0, 64'h1200,                7'd50, 64'hFFFF_FFFF_FF00_FFFF}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic sc, input logic [6:0] base, input logic [9:0] idx,
                         input logic [1:0] w, input logic be, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrScalar = sc; wrBase = base; wrIndex = idx;
    wrWidth = w; wrBigEnd = be; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [6:0] r, output logic [63:0] val);
    rdScalar = 1'b1; rdBase = r; rdIndex = '0; rdWidth = '0; rdBigEnd = 1'b0;
    #1 val = rdData;
  endtask

  task automatic readElem(input logic [6:0] base, input logic [9:0] idx, input logic [1:0] w,
                          input logic be, output logic [63:0] val);
    rdScalar = 1'b0; rdBase = base; rdIndex = idx; rdWidth = w; rdBigEnd = be;
    #1 val = rdData;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(7'd0, v);   check("R1 reg0 after reset", v, 64'h0);
    readReg(7'd5, v);   check("R1 reg5 after reset", v, 64'h0);
    readReg(7'd127, v); check("R1 reg127 after reset", v, 64'h0);

    // table walk: R2 scalar, R3 targeting, R4/R5 lanes, R6 byte preservation, R7 readback
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] expElem;
      doWrite(VECS[i].sc, VECS[i].base, VECS[i].idx, VECS[i].w, VECS[i].be, VECS[i].data);
      readReg(VECS[i].chkReg, v);
      check($sformatf("%s vec%0d register", VECS[i].sc ? "R2" : (VECS[i].be ? "R3 R5 R6" : "R3 R4 R6"), i),
            v, VECS[i].expReg);
      if (!VECS[i].sc) begin
        expElem = (VECS[i].w == 2'd0) ? VECS[i].data
                : (VECS[i].data & ((64'd1 << (64 >> VECS[i].w)) - 64'd1));
        readElem(VECS[i].base, VECS[i].idx, VECS[i].w, VECS[i].be, v);
        check($sformatf("R7 vec%0d element readback", i), v, expElem);
      end
      @(negedge clk);
    end

    // R7: same register seen through different element views
    readElem(7'd5, 10'd0, 2'd2, 1'b1, v); check("R7 reg5 BE elem0 16b", v, 64'h1122);
    readElem(7'd5, 10'd3, 2'd2, 1'b0, v); check("R7 reg5 LE elem3 16b", v, 64'h1122);
    readElem(7'd5, 10'd0, 2'd2, 1'b0, v); check("R7 reg5 LE elem0 16b", v, 64'h1234);
    readElem(7'd5, 10'd1, 2'd1, 1'b1, v); check("R7 reg5 BE elem1 32b", v, 64'h1234);

    // R8: last in-range byte
    @(negedge clk);
    wrEn = 1'b1; wrScalar = 1'b0; wrBase = 7'd127; wrIndex = 10'd7;
    wrWidth = 2'd3; wrBigEnd = 1'b0; wrData = 64'h5A;
    #1 check("R8 edge write flag", {63'b0, wrOutOfRange}, 64'h0);
    @(negedge clk);
    wrEn = 1'b0;
    readReg(7'd127, v); check("R8 reg127 last lane", v, 64'h5A00_0000_0000_0000);

    // R8: write past the last register is dropped
    @(negedge clk);
    wrEn = 1'b1; wrScalar = 1'b0; wrBase = 7'd120; wrIndex = 10'd10;
    wrWidth = 2'd0; wrBigEnd = 1'b0; wrData = 64'h99;
    readElem(7'd120, 10'd10, 2'd0, 1'b0, v);
    check("R8 write flag", {63'b0, wrOutOfRange}, 64'h1);
    check("R8 read flag", {63'b0, rdOutOfRange}, 64'h1);
    check("R8 read data zero", v, 64'h0);
    @(negedge clk);
    wrEn = 1'b0;
    readReg(7'd2, v);   check("R8 wrapped reg2 untouched", v, 64'h0);
    readReg(7'd127, v); check("R8 reg127 untouched", v, 64'h5A00_0000_0000_0000);

    // R9: read during write returns old data
    @(negedge clk);
    wrEn = 1'b1; wrScalar = 1'b1; wrBase = 7'd60; wrIndex = '0;
    wrWidth = 2'd0; wrBigEnd = 1'b0; wrData = 64'h1111;
    readReg(7'd60, v); check("R9 same-cycle old data", v, 64'h0);
    @(negedge clk);
    wrEn = 1'b0;
    readReg(7'd60, v); check("R9 next-cycle new data", v, 64'h1111);

    // R1: reset in mid-run clears contents
    @(negedge clk);
    rstN = 1'b0;
    readReg(7'd5, v); check("R1 reg5 cleared by reset", v, 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    readReg(7'd50, v); check("R1 reg50 cleared by reset", v, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule